// File: doc/BRIEF.md
# Scaled Effective Address Generator

This block forms a memory address from up to three terms: a base register value, an index register value multiplied by an element size, and a constant displacement. Each register term can be switched off on its own, so the same block covers plain direct, register-pointer, base-plus-offset, indexed and fully combined forms. The result is captured in an output register one cycle after a request strobe. It is a pure address: no memory is read, so it also serves as the result of a load-effective-address operation.

Two addressing widths are supported. In the wide mode any of the eight general registers may supply the base or the index, and the sum wraps modulo 2^32. In the narrow 16-bit mode only four registers may act as pointers. Any other pointer register raises an error flag. The result is cut to its low 16 bits.

A typical use is walking a row-major two-dimensional array. The base holds the row number times the row length in bytes, the index holds the column, and the scale matches the element size.

Top module: `eff_addr_gen`

## Requirements
- R1: After reset, out_valid, out_err and out_addr are all zero.
- R2: A request with req_valid high gives out_valid high on the next clock edge for exactly one cycle per requesting cycle; without a request out_valid is low.
- R3: In wide mode (mode_16 = 0) out_addr = base + index × scale + disp, taken modulo 2^32, with a disabled term contributing zero.
- R4: scale_code 0, 1, 2, 3 multiplies the index by 1, 2, 4, 8 respectively.
- R5: In wide mode out_err is never set, whatever register numbers are given.
- R6: In 16-bit mode out_err is set when an enabled base or an enabled index uses a register number other than 3, 5, 6 or 7. These are the only legal pointer numbers in the 0..7 register numbering.
- R7: In 16-bit mode out_addr is the same sum truncated to 16 bits, and bits 31:16 are zero.
- R8: In a cycle with no request, out_addr and out_err keep their previous values.
- R9: The register number and the value of a disabled base or index are ignored: they affect neither out_addr nor out_err.
- R10: For a 5-column doubleword array with base = 2 × 20 and index = 3 at scale 4 and zero displacement, the address is 52.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| mode_16 | input | 1 | 1 selects 16-bit addressing |
| base_en | input | 1 | Base term enabled |
| base_id | input | 3 | Base register number |
| base_val | input | 32 | Base register value |
| index_en | input | 1 | Index term enabled |
| index_id | input | 3 | Index register number |
| index_val | input | 32 | Index register value |
| scale_code | input | 2 | Index scale: 1 << scale_code |
| disp | input | 32 | Displacement |
| out_valid | output | 1 | Result valid pulse |
| out_addr | output | 32 | Computed address |
| out_err | output | 1 | Illegal pointer register in 16-bit mode |

## Verification
On every cycle the assertions check four things: the one-cycle valid timing, the absence of errors in wide mode, the zero upper half in 16-bit mode, and the holding of the result between requests. The arithmetic itself, the scale mapping, the exact legal register set, and the indifference to disabled terms can only be shown by the bench's scenarios. The bench compares every cycle against its behavioural model, under directed cases and a random sweep. That includes the array-offset example and wrap-around sums.

// File: rtl/eag_pkg.sv
package eag_pkg;
    typedef enum logic [1:0] {
        SCL_BYTE  = 2'd0,
        SCL_HALF  = 2'd1,
        SCL_WORD  = 2'd2,
        SCL_QUAD  = 2'd3
    } scale_e;

    localparam logic [2:0] RID_BX = 3'd3;
    localparam logic [2:0] RID_BP = 3'd5;
    localparam logic [2:0] RID_SI = 3'd6;
    localparam logic [2:0] RID_DI = 3'd7;
endpackage

// File: rtl/eag_index_scaler.sv
module eag_index_scaler #(
    parameter int W       = 32,
    parameter int SCALE_W = 2
) (
    input  logic               en,
    input  logic [W-1:0]       val,
    input  logic [SCALE_W-1:0] scale,
    output logic [W-1:0]       term
);
    localparam int NUM_SCALES = 1 << SCALE_W;

    logic [W-1:0] shifted [NUM_SCALES];

    genvar g;
    generate
        for (g = 0; g < NUM_SCALES; g++) begin : g_shift
            assign shifted[g] = val << g;
        end
    endgenerate

    assign term = en ? shifted[scale] : '0;
endmodule

// File: rtl/eag_ptr_check.sv
module eag_ptr_check #(
    parameter int ID_W = 3,
    parameter logic [(1<<ID_W)-1:0] LEGAL_MASK = 8'b1110_1000
) (
    input  logic            mode_16,
    input  logic            base_en,
    input  logic [ID_W-1:0] base_id,
    input  logic            index_en,
    input  logic [ID_W-1:0] index_id,
    output logic            illegal
);
    logic base_bad;
    logic index_bad;

    always_comb begin
        base_bad  = base_en  && !LEGAL_MASK[base_id];
        index_bad = index_en && !LEGAL_MASK[index_id];
        illegal   = mode_16 && (base_bad || index_bad);
    end
endmodule

// File: rtl/eag_sum3.sv
module eag_sum3 #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] sum
);
    assign sum = a + b + c;
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen #(
    parameter int ADDR_W  = 32,
    parameter int ID_W    = 3,
    parameter int SCALE_W = 2,
    parameter int SHORT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               mode_16,
    input  logic               base_en,
    input  logic [ID_W-1:0]    base_id,
    input  logic [ADDR_W-1:0]  base_val,
    input  logic               index_en,
    input  logic [ID_W-1:0]    index_id,
    input  logic [ADDR_W-1:0]  index_val,
    input  logic [SCALE_W-1:0] scale_code,
    input  logic [ADDR_W-1:0]  disp,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               out_err
);
    import eag_pkg::*;

    localparam int NUM_IDS = 1 << ID_W;
    localparam logic [ADDR_W-1:0] SHORT_MASK =
        {{(ADDR_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};
    localparam logic [NUM_IDS-1:0] LEGAL16 =
        (NUM_IDS'(1) << RID_BX) | (NUM_IDS'(1) << RID_BP) |
        (NUM_IDS'(1) << RID_SI) | (NUM_IDS'(1) << RID_DI);

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [ADDR_W-1:0] addr;
    } res_t;

    res_t res_d, res_q;

    logic [ADDR_W-1:0] base_term;
    logic [ADDR_W-1:0] index_term;
    logic [ADDR_W-1:0] raw_sum;
    logic              bad_ptr;

    assign base_term = base_en ? base_val : '0;

    eag_index_scaler #(.W(ADDR_W), .SCALE_W(SCALE_W)) u_scaler (
        .en    (index_en),
        .val   (index_val),
        .scale (scale_code),
        .term  (index_term)
    );

    eag_sum3 #(.W(ADDR_W)) u_sum (
        .a   (base_term),
        .b   (index_term),
        .c   (disp),
        .sum (raw_sum)
    );

    eag_ptr_check #(.ID_W(ID_W), .LEGAL_MASK(LEGAL16)) u_check (
        .mode_16  (mode_16),
        .base_en  (base_en),
        .base_id  (base_id),
        .index_en (index_en),
        .index_id (index_id),
        .illegal  (bad_ptr)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = req_valid;
        if (req_valid) begin
            res_d.err  = bad_ptr;
            res_d.addr = mode_16 ? (raw_sum & SHORT_MASK) : raw_sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign out_addr  = res_q.addr;
    assign out_err   = res_q.err;
endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
    parameter int ADDR_W  = 32,
    parameter int SHORT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              mode_16,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_err
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    assert_no_err_wide_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mode_16) |=> !out_err);

    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode_16) |=> (out_addr[ADDR_W-1:SHORT_W] == '0));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(out_addr) && $stable(out_err)));
endmodule

bind eff_addr_gen eag_checker #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_eag_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .mode_16   (mode_16),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .out_err   (out_err)
);

// File: tb/tb_eff_addr_gen.sv
module tb_eff_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        mode_16 = 1'b0;
    logic        base_en = 1'b0;
    logic [2:0]  base_id = '0;
    logic [31:0] base_val = '0;
    logic        index_en = 1'b0;
    logic [2:0]  index_id = '0;
    logic [31:0] index_val = '0;
    logic [1:0]  scale_code = '0;
    logic [31:0] disp = '0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic        out_err;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";
    bit    done    = 0;

    logic        exp_valid = 0;
    logic [31:0] exp_addr  = 0;
    logic        exp_err   = 0;

    always #4 clk = ~clk;

    eff_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode_16(mode_16),
        .base_en(base_en), .base_id(base_id), .base_val(base_val),
        .index_en(index_en), .index_id(index_id), .index_val(index_val),
        .scale_code(scale_code), .disp(disp),
        .out_valid(out_valid), .out_addr(out_addr), .out_err(out_err)
    );

    function automatic bit ptr_ok16(input int id);
        return (id == 3) || (id == 5) || (id == 6) || (id == 7);
    endfunction

    // behavioural reference model, advanced on each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_valid <= 0;
            exp_addr  <= 0;
            exp_err   <= 0;
        end else begin
            exp_valid <= req_valid;
            if (req_valid) begin
                longint total;
                longint mult;
                mult  = 1;
                for (int k = 0; k < int'(scale_code); k++) mult = mult * 2;
                total = longint'(disp);
                if (base_en)  total = total + longint'(base_val);
                if (index_en) total = total + longint'(index_val) * mult;
                total = total % 64'h1_0000_0000;
                if (mode_16) total = total % 64'h1_0000;
                exp_addr <= total[31:0];
                exp_err  <= mode_16 &&
                            ((base_en && !ptr_ok16(int'(base_id))) ||
                             (index_en && !ptr_ok16(int'(index_id))));
            end
        end
    end

    // compare on every falling edge, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_tests++;
            if (out_valid !== exp_valid || out_addr !== exp_addr || out_err !== exp_err) begin
                n_fail++;
                $display("FAIL %s: got v=%0b a=%08h e=%0b, expected v=%0b a=%08h e=%0b",
                         cur_req, out_valid, out_addr, out_err, exp_valid, exp_addr, exp_err);
            end
        end
    end

    task automatic req(input bit m16, input bit be, input int bid, input logic [31:0] bv,
                       input bit ie, input int iid, input logic [31:0] iv,
                       input int sc, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1; mode_16 = m16;
        base_en = be; base_id = 3'(bid); base_val = bv;
        index_en = ie; index_id = 3'(iid); index_val = iv;
        scale_code = 2'(sc); disp = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 0;
            base_val  = $urandom; index_val = $urandom; disp = $urandom;
            base_id   = 3'($urandom); index_id = 3'($urandom);
        end
    endtask

    task automatic check_direct(input string tag, input logic [31:0] a, input logic e);
        @(negedge clk);
        req_valid = 0;
        #1;
        n_tests++;
        if (out_valid !== 1'b1 || out_addr !== a || out_err !== e) begin
            n_fail++;
            $display("FAIL %s: got v=%0b a=%08h e=%0b, expected v=1 a=%08h e=%0b",
                     tag, out_valid, out_addr, out_err, a, e);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        n_tests++;
        if (out_valid !== 0 || out_addr !== 0 || out_err !== 0) begin
            n_fail++;
            $display("FAIL R1: got v=%0b a=%08h e=%0b, expected all zero",
                     out_valid, out_addr, out_err);
        end
        rst_n = 1;
        idle(2);

        // R3 / R10: 2D array row 2 column 3, doubleword elements, 5 columns
        cur_req = "R10";
        req(0, 1, 3, 32'd40, 1, 6, 32'd3, 2, 32'd0);
        check_direct("R10", 32'd52, 1'b0);

        // R3: wrap modulo 2^32 and displacement-only form
        cur_req = "R3";
        req(0, 1, 0, 32'hFFFF_FFF0, 1, 1, 32'h10, 1, 32'h5);
        check_direct("R3", 32'h0000_0015, 1'b0);
        req(0, 0, 2, 32'h1234, 0, 4, 32'h99, 3, 32'hCAFE_0000);
        check_direct("R3", 32'hCAFE_0000, 1'b0);

        // R4: each scale code on the same index
        cur_req = "R4";
        for (int s = 0; s < 4; s++) begin
            req(0, 0, 0, 0, 1, 7, 32'h0000_0003, s, 32'h100);
            check_direct("R4", 32'h100 + (32'd3 << s), 1'b0);
        end

        // R5: any register legal in wide mode
        cur_req = "R5";
        req(0, 1, 4, 32'h10, 1, 0, 32'h1, 0, 0);
        check_direct("R5", 32'h11, 1'b0);

        // R6: illegal base, illegal index, legal pair
        cur_req = "R6";
        req(1, 1, 0, 32'h10, 1, 6, 32'h2, 0, 0);
        check_direct("R6", 32'h12, 1'b1);
        req(1, 1, 3, 32'h10, 1, 2, 32'h2, 0, 0);
        check_direct("R6", 32'h12, 1'b1);
        req(1, 1, 5, 32'h10, 1, 7, 32'h2, 1, 0);
        check_direct("R6", 32'h14, 1'b0);

        // R7: truncation in 16-bit mode
        cur_req = "R7";
        req(1, 1, 3, 32'h0001_FFF0, 1, 6, 32'h0000_0020, 0, 32'h0);
        check_direct("R7", 32'h0000_0010, 1'b0);

        // R9: disabled illegal register ignored in 16-bit mode
        cur_req = "R9";
        req(1, 0, 1, 32'hDEAD_BEEF, 1, 3, 32'h4, 2, 32'h1);
        check_direct("R9", 32'h11, 1'b0);

        // R8: outputs hold across idle cycles with changing inputs
        cur_req = "R8";
        req(0, 1, 2, 32'h0000_1000, 0, 0, 0, 0, 32'h4);
        idle(6);

        // R2: back-to-back requests, random sweep compared every cycle
        cur_req = "R2";
        for (int i = 0; i < 400; i++) begin
            req($urandom % 2, $urandom % 2, $urandom % 8, $urandom,
                $urandom % 2, $urandom % 8, $urandom, $urandom % 4, $urandom);
            if ($urandom % 3 == 0) idle(1 + $urandom % 3);
        end
        idle(3);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule